// File: doc/BRIEF.md
# Tag-Matching Reservation Station Array

This block holds a small pool of waiting operations for one class of functional unit in an out-of-order core. An issued operation arrives with, for each of its two source operands, either a value or the tag of the station that will produce it. Operands that are still pending are filled by watching a result broadcast bus. Every cycle the bus can carry one tag together with its value, and any pending slot whose tag matches takes that value.

When both operands of a station are present, the station becomes a candidate for dispatch. Each cycle at most one candidate goes to the single functional unit. If several are ready, the one issued earliest is chosen. A station keeps its slot from issue until the completion input names its tag. After that the slot can be reused. When every slot is occupied, the issue port raises a stall and ignores the offered operation.

Top module: `rs_array`

## Requirements
- R1: After reset no station is occupied: `iss_stall` is 0, `disp_valid` is 0 and `iss_tag` is 1.
- R2: An accepted operation enters the free station with the lowest index i. `iss_tag` shows that station's tag, i+1, in the same cycle. Tag value 0 is never a station and means "no producer".
- R3: While all stations are occupied, `iss_stall` is 1 and `iss_tag` is 0. An operation offered then is dropped and never dispatches.
- R4: When `cdb_valid` is 1 and `cdb_tag` equals a station's nonzero pending tag for operand j or k, the station stores `cdb_value` as that operand and clears the pending tag. A bus tag of 0 matches nothing.
- R5: A station is offered for dispatch only when it is occupied, both pending tags are 0, and it has not been dispatched before. An operand captured from the bus makes the station eligible in the following cycle.
- R6: If several stations are eligible in the same cycle, the one accepted earliest is dispatched. At most one station dispatches per cycle.
- R7: If an operation is accepted in the same cycle that the bus carries a tag matching one of its pending operand tags, the new station captures the bus value.
- R8: A station is dispatched at most once for each time it is occupied.
- R9: When `done_valid` is 1 and `done_tag` names an occupied station, that station becomes free from the next cycle. A completion naming a free station or tag 0 has no effect.
- R10: While `disp_valid` is 1, the dispatch port carries the chosen station's tag, opcode, both operand values and its immediate field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| iss_valid | input | 1 | An operation is offered for issue |
| iss_op | input | OP_W | Opcode of the offered operation |
| iss_qj | input | TAG_W | Producer tag of operand j (0: value present) |
| iss_vj | input | DATA_W | Value of operand j |
| iss_qk | input | TAG_W | Producer tag of operand k (0: value present) |
| iss_vk | input | DATA_W | Value of operand k |
| iss_imm | input | IMM_W | Immediate / address field |
| iss_stall | output | 1 | All stations occupied; offer not taken |
| iss_tag | output | TAG_W | Tag given to the offered operation (0 when stalled) |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | TAG_W | Tag of the broadcast result |
| cdb_value | input | DATA_W | Broadcast result value |
| done_valid | input | 1 | A station's result has been broadcast; release it |
| done_tag | input | TAG_W | Tag of the station to release |
| disp_valid | output | 1 | An operation is dispatched this cycle |
| disp_tag | output | TAG_W | Tag of the dispatched station |
| disp_op | output | OP_W | Opcode of the dispatched operation |
| disp_vj | output | DATA_W | Operand j value |
| disp_vk | output | DATA_W | Operand k value |
| disp_imm | output | IMM_W | Immediate / address field |

## Verification
The directed phases use several stimulus patterns. Operations with both operands present check issue placement and dispatch order. Operations waiting on tags check that a broadcast wakes only the matching slots. A broadcast in the same cycle as issue separates capture at issue from a missed wakeup. Filling every slot and then offering one more shows that a stalled offer is really dropped. A long random phase keeps releasing and reissuing stations, so issue age and station index stop agreeing. Stray broadcasts and releases that name idle stations are mixed in. Every clock the bench compares the full dispatch and issue outputs against a queue-based model, and this is where oldest-first selection is told apart from lowest-index selection.

// File: rtl/rs_pkg.sv
package rs_pkg;
  // Tag width needed to name n stations plus the reserved "no producer" value.
  function automatic int tag_bits(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/rs_station.sv
module rs_station #(
  parameter int OP_W   = 4,
  parameter int DATA_W = 16,
  parameter int IMM_W  = 12,
  parameter int TAG_W  = 3,
  parameter logic [TAG_W-1:0] MY_TAG = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [OP_W-1:0]   ld_op,
  input  logic [TAG_W-1:0]  ld_qj,
  input  logic [DATA_W-1:0] ld_vj,
  input  logic [TAG_W-1:0]  ld_qk,
  input  logic [DATA_W-1:0] ld_vk,
  input  logic [IMM_W-1:0]  ld_imm,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  input  logic              grant,
  input  logic              done_valid,
  input  logic [TAG_W-1:0]  done_tag,
  output logic              busy,
  output logic              ready,
  output logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] vj,
  output logic [DATA_W-1:0] vk,
  output logic [IMM_W-1:0]  imm
);
  logic              busy_q, busy_d, sent_q, sent_d;
  logic [OP_W-1:0]   op_q, op_d;
  logic [TAG_W-1:0]  qj_q, qj_d, qk_q, qk_d;
  logic [DATA_W-1:0] vj_q, vj_d, vk_q, vk_d;
  logic [IMM_W-1:0]  imm_q, imm_d;
  logic              free_hit, hit_j, hit_k;

  assign free_hit = done_valid && (done_tag == MY_TAG) && busy_q;
  // Snoop either the stored pending tag or the tag being loaded this cycle.
  assign hit_j = cdb_valid && (cdb_tag != '0) && (cdb_tag == (load ? ld_qj : qj_q));
  assign hit_k = cdb_valid && (cdb_tag != '0) && (cdb_tag == (load ? ld_qk : qk_q));

  always_comb begin
    busy_d = busy_q;
    sent_d = sent_q;
    op_d   = op_q;
    imm_d  = imm_q;
    qj_d   = qj_q;
    qk_d   = qk_q;
    vj_d   = vj_q;
    vk_d   = vk_q;
    if (grant) sent_d = 1'b1;
    if (load) begin
      busy_d = 1'b1;
      sent_d = 1'b0;
      op_d   = ld_op;
      imm_d  = ld_imm;
      qj_d   = ld_qj;
      qk_d   = ld_qk;
      vj_d   = ld_vj;
      vk_d   = ld_vk;
    end else if (free_hit) begin
      busy_d = 1'b0;
      sent_d = 1'b0;
    end
    if (hit_j && (load || busy_q)) begin
      vj_d = cdb_value;
      qj_d = '0;
    end
    if (hit_k && (load || busy_q)) begin
      vk_d = cdb_value;
      qk_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sent_q <= 1'b0;
      qj_q   <= '0;
      qk_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sent_q <= sent_d;
      qj_q   <= qj_d;
      qk_q   <= qk_d;
    end
  end

  // Payload registers need no reset: they are qualified by busy_q.
  always_ff @(posedge clk) begin
    op_q  <= op_d;
    imm_q <= imm_d;
    vj_q  <= vj_d;
    vk_q  <= vk_d;
  end

  assign busy  = busy_q;
  assign ready = busy_q && !sent_q && (qj_q == '0) && (qk_q == '0);
  assign op    = op_q;
  assign vj    = vj_q;
  assign vk    = vk_q;
  assign imm   = imm_q;

  a_r5_grant_needs_operands: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (busy_q && qj_q == '0 && qk_q == '0));
  a_r8_single_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !grant);
  a_r4_snoop_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !load && cdb_valid && qj_q != '0 && cdb_tag == qj_q)
      |=> (qj_q == '0 && vj_q == $past(cdb_value)));
  a_r7_issue_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (load && cdb_valid && ld_qk != '0 && cdb_tag == ld_qk)
      |=> (qk_q == '0 && vk_q == $past(cdb_value)));
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_tag == MY_TAG && busy_q && !load) |=> !busy_q);
endmodule

// File: rtl/rs_oldest_pick.sv
module rs_oldest_pick #(
  parameter int N = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        ready,
  input  logic [N-1:0][N-1:0] older,   // older[j][i]: station j issued before station i
  output logic [N-1:0]        grant
);
  for (genvar i = 0; i < N; i++) begin : g_pick
    logic [N-1:0] beaten_by;
    for (genvar j = 0; j < N; j++) begin : g_cmp
      if (j == i) begin : g_self
        assign beaten_by[j] = 1'b0;
      end else begin : g_other
        assign beaten_by[j] = ready[j] && older[j][i];
      end
    end
    assign grant[i] = ready[i] && !(|beaten_by);
  end

  a_r6_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r6_winner_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (|ready) |-> (|grant));
endmodule

// File: rtl/rs_array.sv
module rs_array #(
  parameter int N_ENT  = 4,
  parameter int OP_W   = 4,
  parameter int DATA_W = 16,
  parameter int IMM_W  = 12,
  localparam int TAG_W = rs_pkg::tag_bits(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [TAG_W-1:0]  iss_qj,
  input  logic [DATA_W-1:0] iss_vj,
  input  logic [TAG_W-1:0]  iss_qk,
  input  logic [DATA_W-1:0] iss_vk,
  input  logic [IMM_W-1:0]  iss_imm,
  output logic              iss_stall,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  input  logic              done_valid,
  input  logic [TAG_W-1:0]  done_tag,
  output logic              disp_valid,
  output logic [TAG_W-1:0]  disp_tag,
  output logic [OP_W-1:0]   disp_op,
  output logic [DATA_W-1:0] disp_vj,
  output logic [DATA_W-1:0] disp_vk,
  output logic [IMM_W-1:0]  disp_imm
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic [N_ENT-1:0]             busy_v, ready_v, grant_v, load_v;
  logic [N_ENT-1:0][OP_W-1:0]   op_v;
  logic [N_ENT-1:0][DATA_W-1:0] vj_v, vk_v;
  logic [N_ENT-1:0][IMM_W-1:0]  imm_v;
  logic [N_ENT-1:0][N_ENT-1:0]  older_q, older_d;
  logic [N_ENT-1:0]             free_onehot;
  logic                         accept;

  // Lowest-index free station.
  always_comb begin
    free_onehot = '0;
    iss_tag     = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (!busy_v[i]) begin
        free_onehot = '0;
        free_onehot[i] = 1'b1;
        iss_tag = TAG_W'(i + 1);
      end
    end
  end

  assign iss_stall = &busy_v;
  assign accept    = iss_valid && !iss_stall;
  assign load_v    = accept ? free_onehot : '0;

  for (genvar i = 0; i < N_ENT; i++) begin : g_st
    rs_station #(
      .OP_W(OP_W), .DATA_W(DATA_W), .IMM_W(IMM_W), .TAG_W(TAG_W),
      .MY_TAG(TAG_W'(i + 1))
    ) u_st (
      .clk(clk), .rst_n(rst_i_n), .load(load_v[i]),
      .ld_op(iss_op), .ld_qj(iss_qj), .ld_vj(iss_vj),
      .ld_qk(iss_qk), .ld_vk(iss_vk), .ld_imm(iss_imm),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
      .grant(grant_v[i]), .done_valid(done_valid), .done_tag(done_tag),
      .busy(busy_v[i]), .ready(ready_v[i]),
      .op(op_v[i]), .vj(vj_v[i]), .vk(vk_v[i]), .imm(imm_v[i])
    );
  end

  // Age matrix: a newly loaded station is younger than every occupied one.
  always_comb begin
    older_d = older_q;
    for (int k = 0; k < N_ENT; k++) begin
      if (load_v[k]) begin
        for (int i = 0; i < N_ENT; i++) begin
          older_d[k][i] = 1'b0;
          older_d[i][k] = (i != k) && busy_v[i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) older_q <= '0;
    else          older_q <= older_d;
  end

  rs_oldest_pick #(.N(N_ENT)) u_pick (
    .clk(clk), .rst_n(rst_i_n), .ready(ready_v), .older(older_q), .grant(grant_v)
  );

  always_comb begin
    disp_valid = |grant_v;
    disp_tag   = '0;
    disp_op    = '0;
    disp_vj    = '0;
    disp_vk    = '0;
    disp_imm   = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (grant_v[i]) begin
        disp_tag = disp_tag | TAG_W'(i + 1);
        disp_op  = disp_op  | op_v[i];
        disp_vj  = disp_vj  | vj_v[i];
        disp_vk  = disp_vk  | vk_v[i];
        disp_imm = disp_imm | imm_v[i];
      end
    end
  end

  a_r3_stall_drops: assert property (@(posedge clk) disable iff (!rst_i_n)
    (iss_valid && iss_stall && !done_valid) |=> (busy_v == $past(busy_v)));
  a_r2_issue_occupies: assert property (@(posedge clk) disable iff (!rst_i_n)
    (accept) |=> ((busy_v & $past(free_onehot)) != '0));
endmodule

// File: tb/sim_rs_array.sv
module sim_rs_array;
  localparam int N = 4, OPW = 4, DW = 16, IW = 12;
  localparam int TW = rs_pkg::tag_bits(N);

  logic clk = 1'b0, rst_n = 1'b0;
  always #2ns clk = ~clk;

  logic iss_valid, cdb_valid, done_valid;
  logic [OPW-1:0] iss_op;
  logic [TW-1:0]  iss_qj, iss_qk, cdb_tag, done_tag;
  logic [DW-1:0]  iss_vj, iss_vk, cdb_value;
  logic [IW-1:0]  iss_imm;
  logic iss_stall, disp_valid;
  logic [TW-1:0]  iss_tag, disp_tag;
  logic [OPW-1:0] disp_op;
  logic [DW-1:0]  disp_vj, disp_vk;
  logic [IW-1:0]  disp_imm;

  rs_array #(.N_ENT(N), .OP_W(OPW), .DATA_W(DW), .IMM_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_qj(iss_qj), .iss_vj(iss_vj), .iss_qk(iss_qk), .iss_vk(iss_vk),
    .iss_imm(iss_imm), .iss_stall(iss_stall), .iss_tag(iss_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
    .done_valid(done_valid), .done_tag(done_tag), .disp_valid(disp_valid),
    .disp_tag(disp_tag), .disp_op(disp_op), .disp_vj(disp_vj),
    .disp_vk(disp_vk), .disp_imm(disp_imm));

  int tests = 0, fails = 0;
  string phase = "R1";

  // Behavioural reference model.
  bit m_busy[N], m_sent[N];
  int m_op[N], m_vj[N], m_vk[N], m_qj[N], m_qk[N], m_imm[N];
  int m_order[$];

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] %s act=%0d exp=%0d", req, phase, what, act, exp);
    end
  endtask

  function automatic int m_pick();
    foreach (m_order[k]) begin
      int s = m_order[k];
      if (m_busy[s] && !m_sent[s] && m_qj[s] == 0 && m_qk[s] == 0) return s;
    end
    return -1;
  endfunction

  function automatic int m_free();
    for (int i = 0; i < N; i++) if (!m_busy[i]) return i;
    return -1;
  endfunction

  // Compare outputs against the model, then advance the model by one clock.
  task automatic step();
    int fr, pk;
    #1ns;
    fr = m_free();
    pk = m_pick();
    chk("R3", "iss_stall", int'(iss_stall), int'(fr < 0));
    chk("R2", "iss_tag", int'(iss_tag), fr < 0 ? 0 : fr + 1);
    chk("R5", "disp_valid", int'(disp_valid), int'(pk >= 0));
    if (pk >= 0) begin
      chk("R6", "disp_tag", int'(disp_tag), pk + 1);
      chk("R10", "disp_op", int'(disp_op), m_op[pk]);
      chk("R4", "disp_vj", int'(disp_vj), m_vj[pk]);
      chk("R4", "disp_vk", int'(disp_vk), m_vk[pk]);
      chk("R10", "disp_imm", int'(disp_imm), m_imm[pk]);
      m_sent[pk] = 1;
    end
    if (cdb_valid && cdb_tag != 0) begin
      for (int i = 0; i < N; i++) if (m_busy[i]) begin
        if (m_qj[i] == int'(cdb_tag)) begin m_qj[i] = 0; m_vj[i] = int'(cdb_value); end
        if (m_qk[i] == int'(cdb_tag)) begin m_qk[i] = 0; m_vk[i] = int'(cdb_value); end
      end
    end
    if (done_valid && done_tag != 0 && int'(done_tag) <= N && m_busy[done_tag-1]) begin
      int s = int'(done_tag) - 1;
      m_busy[s] = 0;
      m_sent[s] = 0;
      foreach (m_order[k]) if (m_order[k] == s) begin m_order.delete(k); break; end
    end
    if (iss_valid && fr >= 0) begin
      m_busy[fr] = 1; m_sent[fr] = 0;
      m_op[fr] = int'(iss_op); m_imm[fr] = int'(iss_imm);
      m_qj[fr] = int'(iss_qj); m_vj[fr] = int'(iss_vj);
      m_qk[fr] = int'(iss_qk); m_vk[fr] = int'(iss_vk);
      if (cdb_valid && cdb_tag != 0 && m_qj[fr] == int'(cdb_tag)) begin m_qj[fr] = 0; m_vj[fr] = int'(cdb_value); end
      if (cdb_valid && cdb_tag != 0 && m_qk[fr] == int'(cdb_tag)) begin m_qk[fr] = 0; m_vk[fr] = int'(cdb_value); end
      m_order.push_back(fr);
    end
    @(negedge clk);
    iss_valid = 0; cdb_valid = 0; done_valid = 0;
  endtask

  task automatic issue(int op, int qj, int vj, int qk, int vk, int imm);
    iss_valid = 1; iss_op = OPW'(op); iss_imm = IW'(imm);
    iss_qj = TW'(qj); iss_vj = DW'(vj); iss_qk = TW'(qk); iss_vk = DW'(vk);
  endtask

  task automatic bcast(int tag, int val);
    cdb_valid = 1; cdb_tag = TW'(tag); cdb_value = DW'(val);
  endtask

  task automatic release_tag(int tag);
    done_valid = 1; done_tag = TW'(tag);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    iss_valid = 0; cdb_valid = 0; done_valid = 0;
    iss_op = 0; iss_qj = 0; iss_qk = 0; iss_vj = 0; iss_vk = 0; iss_imm = 0;
    cdb_tag = 0; cdb_value = 0; done_tag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset iss_stall", int'(iss_stall), 0);
    chk("R1", "reset disp_valid", int'(disp_valid), 0);
    chk("R1", "reset iss_tag", int'(iss_tag), 1);

    // R2, R6: three waiters on tag 4, woken together; oldest goes first.
    phase = "R2";
    issue(1, 4, 0, 0, 11, 100); step();
    issue(2, 4, 0, 0, 12, 101); step();
    issue(3, 0, 7, 4, 0, 102);  step();
    phase = "R4";
    bcast(4, 555); step();
    phase = "R6";
    repeat (3) step();
    // R9: release stations 1..3; completion for idle station 4 is ignored.
    phase = "R9";
    release_tag(1); step();
    release_tag(4); step();
    release_tag(2); step();
    release_tag(3); step();
    release_tag(0); step();

    // R3: fill all, offer a fifth that must be dropped.
    phase = "R3";
    for (int i = 0; i < N; i++) begin issue(4 + i, 3, 0, 0, i, 200 + i); step(); end
    issue(15, 0, 99, 0, 98, 999); step();
    bcast(3, 321); step();
    repeat (N + 2) step();
    for (int i = 1; i <= N; i++) begin release_tag(i); step(); end

    // R7: issue while the bus carries the matching tag.
    phase = "R7";
    issue(9, 2, 0, 3, 0, 77); bcast(2, 1234); step();
    bcast(3, 4321); step();
    repeat (2) step();
    // R8: dispatched station is not offered again while it stays occupied.
    phase = "R8";
    repeat (3) step();
    release_tag(1); step();

    // Random phase: reuse shuffles age against index.
    phase = "RND";
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 99) < 55)
        issue($urandom_range(0, 15),
              $urandom_range(0, 1) ? 0 : $urandom_range(1, N), $urandom_range(0, 65535),
              $urandom_range(0, 1) ? 0 : $urandom_range(1, N), $urandom_range(0, 65535),
              $urandom_range(0, 4095));
      if ($urandom_range(0, 99) < 40) bcast($urandom_range(0, N), $urandom_range(0, 65535));
      if ($urandom_range(0, 99) < 45) begin
        int s = $urandom_range(0, N - 1);
        if (m_busy[s] && m_sent[s]) begin
          release_tag(s + 1);
          if ($urandom_range(0, 1)) bcast(s + 1, $urandom_range(0, 65535));
        end else if ($urandom_range(0, 9) == 0) release_tag($urandom_range(0, N));
      end
      step();
    end
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired act=hung exp=finished");
    finish_run();
  end
endmodule